// File: doc/BRIEF.md
# Duty Ramp Controller

This block moves a PWM channel's compare value from a programmed starting point toward brighter or dimmer settings in equal increments, so that an LED fades smoothly instead of jumping. Software presents a starting duty, an increment size, a pacing figure (how many timer wrap-arounds pass between increments), an increment count, a direction and an enable. All of these are taken in together on a single update strobe.

Once armed, the block watches a one-cycle pulse from the channel's timer that marks each counter wrap-around. After the programmed number of such pulses it adds or subtracts the increment, clipping at the ends of the duty range. It does this until the increment count is used up, then emits a one-cycle completion pulse. The present duty value is always driven on an output, which feeds both the channel comparator and a status readback path. If the enable is clear at the update strobe, the duty value is simply loaded and held.

Top module: `duty_ramp_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `duty_o` is 0, `busy_o` is 0 and `done_o` is 0 until the first update strobe.
- R2: When `load_i` is high at a clock edge, `duty_o` equals `cfg_duty_i` from the next cycle on, and the other configuration inputs are captured; an `ovf_i` pulse in that same cycle is discarded.
- R3: A strobe with `cfg_start_i` = 0 leaves `busy_o` at 0; `duty_o` then holds its value and `done_o` stays 0 whatever `ovf_i` does until the next strobe.
- R4: While `busy_o` is 1, the duty value changes once per P accepted `ovf_i` pulses, where P is the captured `cfg_cycle_i`, and P = 0 acts as P = 1; cycles without `ovf_i` leave the duty value unchanged.
- R5: Captured `cfg_up_i` = 1 makes each step add the captured `cfg_scale_i`; `cfg_up_i` = 0 makes each step subtract it.
- R6: An adding step that would pass 2^19-1 gives 2^19-1, and a subtracting step that would go below 0 gives 0; the value never wraps.
- R7: Exactly N steps are taken, N being the captured `cfg_count_i`; after the last one `busy_o` falls in the same cycle the last value appears and the duty value then holds.
- R8: `done_o` is high for exactly one cycle, the cycle in which the final stepped value first appears on `duty_o`; a strobe with `cfg_start_i` = 1 and `cfg_count_i` = 0 takes no step and raises `done_o` in the cycle after the strobe.
- R9: A strobe during a fade abandons it without a `done_o` pulse and starts over from the new configuration, with the overflow pacing restarted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Update strobe that captures all configuration inputs |
| cfg_duty_i | input | 19 | Starting duty value |
| cfg_scale_i | input | 10 | Increment applied per step |
| cfg_cycle_i | input | 10 | Timer wrap-arounds per step (0 treated as 1) |
| cfg_count_i | input | 10 | Number of steps to take |
| cfg_up_i | input | 1 | 1: duty rises, 0: duty falls |
| cfg_start_i | input | 1 | Enables the ramp at the strobe |
| ovf_i | input | 1 | One-cycle pulse per timer wrap-around |
| duty_o | output | 19 | Present duty value, to comparator and readback |
| busy_o | output | 1 | A ramp is in progress |
| done_o | output | 1 | One-cycle pulse when a ramp completes |

## Verification
Checked on every cycle by properties are several points: the loaded value appearing after a strobe, the duty value holding when idle or when no wrap-around pulse arrives, monotonic movement in the captured direction, the completion pulse never overlapping activity, and every natural end of a ramp producing that pulse. The exact step sizes, the clipping at both ends of the range, the pacing across several wrap-arounds, the exact number of steps and the abandonment of a ramp on a new strobe depend on whole sequences of stimulus. These are shown only by the bench's directed and random scenarios compared against its cycle model.

// File: rtl/duty_ramp_pkg.sv
package duty_ramp_pkg;

  typedef enum logic {
    RAMP_DOWN = 1'b0,
    RAMP_UP   = 1'b1
  } ramp_dir_e;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RAMP = 1'b1
  } ramp_state_e;

endpackage

// File: rtl/ramp_cfg_latch.sv
module ramp_cfg_latch
  import duty_ramp_pkg::*;
#(
  parameter int FLD_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [FLD_W-1:0] scale_i,
  input  logic [FLD_W-1:0] cycle_i,
  input  logic             up_i,
  output logic [FLD_W-1:0] scale_o,
  output logic [FLD_W-1:0] period_o,
  output ramp_dir_e        dir_o
);

  localparam logic [FLD_W-1:0] ONE = FLD_W'(1);

  logic [FLD_W-1:0] period_eff;

  // A zero pacing figure would never produce a step; treat it as one.
  assign period_eff = (cycle_i == '0) ? ONE : cycle_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_o  <= '0;
      period_o <= ONE;
      dir_o    <= RAMP_DOWN;
    end else if (load_i) begin
      scale_o  <= scale_i;
      period_o <= period_eff;
      dir_o    <= up_i ? RAMP_UP : RAMP_DOWN;
    end
  end

endmodule

// File: rtl/ramp_pacer.sv
module ramp_pacer #(
  parameter int FLD_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             ovf_i,
  input  logic [FLD_W-1:0] period_i,
  output logic             tick_o
);

  logic [FLD_W-1:0] wrap_cnt;
  logic             last_wrap;

  // period_i is never zero, so period_i - 1 cannot underflow.
  assign last_wrap = (wrap_cnt == period_i - FLD_W'(1));
  assign tick_o    = run_i && ovf_i && last_wrap;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      wrap_cnt <= '0;
    end else if (run_i && ovf_i) begin
      wrap_cnt <= last_wrap ? '0 : wrap_cnt + FLD_W'(1);
    end
  end

endmodule

// File: rtl/ramp_stepper.sv
module ramp_stepper
  import duty_ramp_pkg::*;
#(
  parameter int DUTY_W = 19,
  parameter int FLD_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              start_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [FLD_W-1:0]  count_i,
  input  logic              tick_i,
  input  logic [FLD_W-1:0]  scale_i,
  input  ramp_dir_e         dir_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int EXT_W = DUTY_W + 1;

  ramp_state_e       state_q;
  logic [FLD_W-1:0]  left_q;
  logic [DUTY_W-1:0] duty_q;
  logic              done_q;
  logic [EXT_W-1:0]  sum_ext;
  logic [EXT_W-1:0]  dif_ext;
  logic [DUTY_W-1:0] duty_nxt;
  logic              arm;

  assign sum_ext = {1'b0, duty_q} + EXT_W'(scale_i);
  assign dif_ext = {1'b0, duty_q} - EXT_W'(scale_i);

  // Clip instead of wrapping: the carry or borrow bit flags the range end.
  always_comb begin
    if (dir_i == RAMP_UP) begin
      duty_nxt = sum_ext[DUTY_W] ? '1 : sum_ext[DUTY_W-1:0];
    end else begin
      duty_nxt = dif_ext[DUTY_W] ? '0 : dif_ext[DUTY_W-1:0];
    end
  end

  assign arm = start_i && (count_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HOLD;
      left_q  <= '0;
      duty_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        duty_q  <= duty_i;
        left_q  <= count_i;
        state_q <= arm ? ST_RAMP : ST_HOLD;
        done_q  <= start_i && (count_i == '0);
      end else if (state_q == ST_RAMP && tick_i) begin
        duty_q <= duty_nxt;
        left_q <= left_q - FLD_W'(1);
        if (left_q == FLD_W'(1)) begin
          state_q <= ST_HOLD;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign duty_o = duty_q;
  assign busy_o = (state_q == ST_RAMP);
  assign done_o = done_q;

endmodule

// File: rtl/duty_ramp_ctrl.sv
module duty_ramp_ctrl
  import duty_ramp_pkg::*;
#(
  parameter int DUTY_W = 19,
  parameter int FLD_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] cfg_duty_i,
  input  logic [FLD_W-1:0]  cfg_scale_i,
  input  logic [FLD_W-1:0]  cfg_cycle_i,
  input  logic [FLD_W-1:0]  cfg_count_i,
  input  logic              cfg_up_i,
  input  logic              cfg_start_i,
  input  logic              ovf_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              busy_o,
  output logic              done_o
);

  logic [FLD_W-1:0] scale_q;
  logic [FLD_W-1:0] period_q;
  ramp_dir_e        dir_q;
  logic             step_tick;
  logic             run;

  // Ignore wrap-around pulses that coincide with an update strobe.
  assign run = busy_o && !load_i;

  ramp_cfg_latch #(.FLD_W(FLD_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_i),
    .scale_i  (cfg_scale_i),
    .cycle_i  (cfg_cycle_i),
    .up_i     (cfg_up_i),
    .scale_o  (scale_q),
    .period_o (period_q),
    .dir_o    (dir_q)
  );

  ramp_pacer #(.FLD_W(FLD_W)) u_pace (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (load_i),
    .run_i    (run),
    .ovf_i    (ovf_i),
    .period_i (period_q),
    .tick_o   (step_tick)
  );

  ramp_stepper #(.DUTY_W(DUTY_W), .FLD_W(FLD_W)) u_step (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .start_i (cfg_start_i),
    .duty_i  (cfg_duty_i),
    .count_i (cfg_count_i),
    .tick_i  (step_tick),
    .scale_i (scale_q),
    .dir_i   (dir_q),
    .duty_o  (duty_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

endmodule

// File: rtl/duty_ramp_chk.sv
module duty_ramp_chk #(
  parameter int DUTY_W = 19,
  parameter int FLD_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic [DUTY_W-1:0] cfg_duty_i,
  input logic              ovf_i,
  input logic [DUTY_W-1:0] duty_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              dir_up
);

  // R2: a strobe puts the starting value on the output one cycle later
  p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (duty_o == $past(cfg_duty_i)));

  // R3: idle with no strobe, the value holds and no completion appears
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !load_i) |=> ($stable(duty_o) && !done_o));

  // R4: no wrap-around pulse, no step
  p_no_ovf_no_step_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !load_i && !ovf_i) |=> $stable(duty_o));

  // R5: rising ramps never fall
  p_rise_monotone_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !load_i && dir_up) |=> (duty_o >= $past(duty_o)));

  // R5: falling ramps never rise
  p_fall_monotone_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !load_i && !dir_up) |=> (duty_o <= $past(duty_o)));

  // R7: a ramp that ends by itself signals completion
  p_end_signals_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && !$past(load_i)) |-> done_o);

  // R8: completion never overlaps an active ramp
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

endmodule

bind duty_ramp_ctrl duty_ramp_chk #(.DUTY_W(DUTY_W), .FLD_W(FLD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_i     (load_i),
  .cfg_duty_i (cfg_duty_i),
  .ovf_i      (ovf_i),
  .duty_o     (duty_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .dir_up     (dir_q == duty_ramp_pkg::RAMP_UP)
);

// File: tb/duty_ramp_ctrl_tb.sv
`timescale 1ns/1ps
module duty_ramp_ctrl_tb;

  localparam int DUTY_W = 19;
  localparam int FLD_W  = 10;
  localparam int DMAX   = (1 << DUTY_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load = 1'b0;
  logic [DUTY_W-1:0] cfg_duty = '0;
  logic [FLD_W-1:0]  cfg_scale = '0;
  logic [FLD_W-1:0]  cfg_cycle = '0;
  logic [FLD_W-1:0]  cfg_count = '0;
  logic              cfg_up = 1'b0;
  logic              cfg_start = 1'b0;
  logic              ovf = 1'b0;
  logic [DUTY_W-1:0] duty;
  logic              busy;
  logic              done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // cycle model built from the requirements
  int m_duty, m_scale, m_per, m_left, m_cnt;
  bit m_up, m_busy, m_done;

  always #5 clk = ~clk;

  duty_ramp_ctrl #(.DUTY_W(DUTY_W), .FLD_W(FLD_W)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load),
    .cfg_duty_i  (cfg_duty),
    .cfg_scale_i (cfg_scale),
    .cfg_cycle_i (cfg_cycle),
    .cfg_count_i (cfg_count),
    .cfg_up_i    (cfg_up),
    .cfg_start_i (cfg_start),
    .ovf_i       (ovf),
    .duty_o      (duty),
    .busy_o      (busy),
    .done_o      (done)
  );

  function automatic int sat_step(int d, int s, bit up);
    if (up) return (d + s > DMAX) ? DMAX : d + s;
    return (s > d) ? 0 : d - s;
  endfunction

  function automatic void model_edge();
    if (rst) begin
      m_duty = 0; m_busy = 0; m_done = 0; m_left = 0; m_cnt = 0;
      m_scale = 0; m_per = 1; m_up = 0;
    end else if (load) begin
      m_duty  = int'(cfg_duty);
      m_scale = int'(cfg_scale);
      m_per   = (cfg_cycle == 0) ? 1 : int'(cfg_cycle);
      m_up    = cfg_up;
      m_left  = int'(cfg_count);
      m_busy  = cfg_start && (cfg_count != 0);
      m_done  = cfg_start && (cfg_count == 0);
      m_cnt   = 0;
    end else begin
      m_done = 0;
      if (m_busy && ovf) begin
        m_cnt++;
        if (m_cnt == m_per) begin
          m_cnt  = 0;
          m_duty = sat_step(m_duty, m_scale, m_up);
          m_left--;
          if (m_left == 0) begin
            m_busy = 0;
            m_done = 1;
          end
        end
      end
    end
  endfunction

  task automatic check(string req);
    vectors++;
    if (int'(duty) != m_duty || busy != m_busy || done != m_done) begin
      miscompares++;
      $display("FAIL %s at %0t: duty=%0d busy=%0b done=%0b expected duty=%0d busy=%0b done=%0b",
               req, $time, duty, busy, done, m_duty, m_busy, m_done);
    end
  endtask

  task automatic tick(bit ld, bit ov, string req);
    load = ld;
    ovf  = ov;
    @(posedge clk);
    model_edge();
    #1;
    check(req);
  endtask

  task automatic set_cfg(int d, int s, int c, int n, bit up, bit st);
    cfg_duty  = DUTY_W'(d);
    cfg_scale = FLD_W'(s);
    cfg_cycle = FLD_W'(c);
    cfg_count = FLD_W'(n);
    cfg_up    = up;
    cfg_start = st;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog: run still active, actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state, with strobe and pulses ignored during reset
    set_cfg(1234, 5, 1, 3, 1, 1);
    tick(1, 1, "R1");
    tick(0, 1, "R1");
    rst = 1'b0;
    tick(0, 1, "R1");
    tick(0, 0, "R1");

    // R3: start clear, value loaded and held
    set_cfg(777, 40, 1, 5, 1, 0);
    tick(1, 0, "R2");
    for (int i = 0; i < 8; i++) tick(0, 1, "R3");

    // R2: strobe together with a pulse; the pulse is discarded
    set_cfg(1000, 10, 1, 2, 1, 1);
    tick(1, 1, "R2");
    for (int i = 0; i < 4; i++) tick(0, 1, "R5 R7");

    // R4: pacing figure zero behaves as one
    set_cfg(500, 7, 0, 3, 0, 1);
    tick(1, 0, "R2");
    for (int i = 0; i < 5; i++) tick(0, 1, "R4");

    // R4: pacing of three with gaps between pulses
    set_cfg(100, 9, 3, 2, 1, 1);
    tick(1, 0, "R2");
    for (int i = 0; i < 16; i++) tick(0, i[0], "R4");

    // R6: clip at the top
    set_cfg(DMAX - 5, 1023, 1, 3, 1, 1);
    tick(1, 0, "R2");
    for (int i = 0; i < 5; i++) tick(0, 1, "R6");

    // R6: clip at zero
    set_cfg(50, 30, 1, 3, 0, 1);
    tick(1, 0, "R2");
    for (int i = 0; i < 5; i++) tick(0, 1, "R6");

    // R8: zero steps requested
    set_cfg(321, 3, 1, 0, 1, 1);
    tick(1, 1, "R8");
    for (int i = 0; i < 3; i++) tick(0, 1, "R8");

    // R9: new strobe in the middle of a ramp
    set_cfg(2000, 100, 2, 6, 1, 1);
    tick(1, 0, "R2");
    for (int i = 0; i < 5; i++) tick(0, 1, "R9");
    set_cfg(9000, 50, 2, 2, 0, 1);
    tick(1, 1, "R9");
    for (int i = 0; i < 8; i++) tick(0, 1, "R9");

    // Random scenarios: R4 R5 R6 R7 R8 R9
    for (int sc = 0; sc < 300; sc++) begin
      int d;
      case ($urandom_range(3))
        0: d = DMAX - int'($urandom_range(2000));
        1: d = int'($urandom_range(2000));
        default: d = int'($urandom_range(DMAX));
      endcase
      set_cfg(d, int'($urandom_range(1023)), int'($urandom_range(3)),
              int'($urandom_range(6)), bit'($urandom_range(1)),
              $urandom_range(9) != 0);
      tick(1, bit'($urandom_range(1)), "R2");
      for (int i = 0; i < 40; i++) begin
        bit ld = ($urandom_range(49) == 0);
        if (ld)
          set_cfg(int'($urandom_range(DMAX)), int'($urandom_range(1023)),
                  int'($urandom_range(3)), int'($urandom_range(6)),
                  bit'($urandom_range(1)), bit'($urandom_range(1)));
        tick(ld, bit'($urandom_range(1)), "R4 R5 R6 R7 R8 R9");
      end
    end

    finish_run();
  end

endmodule